// File: doc/BRIEF.md
# Handshaking Parallel I/O Port

This block gives a host three 8-bit parallel ports, called A, B and C, and a command register. All four are reached through a small synchronous host bus with chip select, read and write strobes and two register address bits. Each port can run as a plain port: reads return the live pins, and writes set a latch that drives the pins. Ports A and B can also run as strobed ports. A strobed input port captures data on an external strobe and keeps it until the host reads it. A strobed output port holds host data and signals that it is pending until an external acknowledge arrives. Port A can also run as a bidirectional port that combines both handshakes on one set of pins.

In the handshake modes, fixed port C bits carry the strobe and acknowledge inputs and the buffer-full and interrupt outputs. Port C bits that no handshake uses stay general-purpose. They follow their group's direction and can be set or cleared one at a time through the command register. Each interrupt request is gated by an enable bit, and the host sets or clears that bit with the same single-bit command. Inputs are sampled on the clock, and every handshake edge is found by comparing a pin with its value in the previous cycle.

Top module: `par_port_hs`

## Requirements
- R1: After reset, ports A, B and C are all plain inputs: pa_oe, pb_oe and pc_oe are all zero, no interrupt is driven, and a command register read returns 8'h9B.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the command register. A command with bit 7 = 1 is a mode set. Its bits 6:5 give the port A mode (00 plain, 01 strobed, 1x bidirectional). Bit 4 = 1 makes port A an input. Bit 3 = 1 makes port C bits 7:4 inputs. Bit 2 = 1 makes port B strobed. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes port C bits 3:0 inputs. A read of address 3 returns the last mode byte.
- R3: In plain mode, an input port read returns its pins in the same cycle. An output port drives all of its enables high and drives its written latch.
- R4: In strobed input mode, a falling strobe (PC4 for port A, PC2 for port B) captures the port pins. From the next cycle the buffer-full flag is high (PC5 for A, PC1 for B). The captured data is held until the host reads the port, even if the pins change.
- R5: A rising strobe while buffer-full is high raises that port's interrupt flag. A host read of the port clears both buffer-full and the interrupt flag by the next cycle.
- R6: In strobed output mode, a host write drives the active-low output-full pin low (PC7 for A, PC1 for B) from the next cycle. A falling acknowledge (PC6 for A, PC2 for B) returns that pin high. A rising acknowledge while it is high raises the interrupt flag, and the next host write clears the flag.
- R7: An interrupt pin (PC3 for A, PC0 for B) is high only while its flag is set and its enable is set. A bit-set command to PC4 enables the port A input side, to PC6 the port A output side, and to PC2 port B. Enabling while a flag is pending raises the pin on the next cycle.
- R8: In bidirectional mode, pa_oe follows the inverse of PC6 with no delay. A falling PC4 captures port A pins, and a port A read returns the captured byte.
- R9: A command with bit 7 = 0 writes bit 0 into the port C latch bit selected by bits 3:1 and changes no other latch bit. In bidirectional mode with port B plain, PC2..PC0 remain general-purpose outputs driven by these commands.
- R10: A mode set clears the A, B and C output latches, all buffer-full and interrupt flags, and all interrupt enables, and it sets the output-full pins high.
- R11: A port C read returns the driven value for each bit with its enable high and the pin value for each other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select for host access |
| rd | input | 1 | Host read strobe, one cycle per access |
| wr | input | 1 | Host write strobe, one cycle per access |
| addr | input | 2 | Register select |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data, combinational from addr |
| pa_in | input | DW | Port A pin values |
| pa_out | output | DW | Port A driven values |
| pa_oe | output | DW | Port A output enables |
| pb_in | input | DW | Port B pin values |
| pb_out | output | DW | Port B driven values |
| pb_oe | output | DW | Port B output enables |
| pc_in | input | 8 | Port C pin values, including strobe and acknowledge inputs |
| pc_out | output | 8 | Port C driven values, including handshake flags |
| pc_oe | output | 8 | Port C output enables |

## Verification
Read data and the port A bidirectional enable are combinational, so the bench samples them one time unit after it drives the inputs, in the same cycle. Each flag, latch, enable and pin that a write, read or strobe edge changes becomes valid one clock edge after the stimulus. The bench drives every stimulus on a falling clock edge and checks these results on the next falling edge, after exactly one rising edge. A reference model of the configuration, updated only when a mode-set write completes, predicts pa_oe and pb_oe, and the bench compares both on every clock.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    PM_SIMPLE  = 2'd0,
    PM_STROBED = 2'd1,
    PM_BIDIR   = 2'd2
  } pmode_t;

  localparam logic [1:0] RA_PORTA = 2'd0;
  localparam logic [1:0] RA_PORTB = 2'd1;
  localparam logic [1:0] RA_PORTC = 2'd2;
  localparam logic [1:0] RA_CMD   = 2'd3;

  // port C bit roles in handshake modes
  localparam int PC_INTR_B = 0;
  localparam int PC_HS_B   = 1;
  localparam int PC_STB_B  = 2;
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef struct packed {
    pmode_t a_mode;
    logic   a_in;
    logic   cu_in;
    logic   b_strobed;
    logic   b_in;
    logic   cl_in;
  } cfg_t;

endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic       wr_pc,
  input  logic [7:0] wdata,
  output cfg_t       cfg,
  output logic       clr,
  output logic [7:0] pc_lat,
  output logic       inte_a_in,
  output logic       inte_a_out,
  output logic       inte_b
);

  localparam int IE_AIN  = 0;
  localparam int IE_AOUT = 1;
  localparam int IE_B    = 2;
  localparam cfg_t CFG_RST = '{a_mode: PM_SIMPLE, a_in: 1'b1, cu_in: 1'b1,
                               b_strobed: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  cfg_t       cfg_q, cfg_d;
  logic [7:0] pc_q, pc_d;
  logic [2:0] ie_q, ie_d;
  logic       mode_set;

  assign mode_set = wr_cmd & wdata[7];

  always_comb begin
    cfg_d = cfg_q;
    pc_d  = pc_q;
    ie_d  = ie_q;
    if (mode_set) begin
      cfg_d.a_mode    = wdata[6] ? PM_BIDIR : (wdata[5] ? PM_STROBED : PM_SIMPLE);
      cfg_d.a_in      = wdata[4];
      cfg_d.cu_in     = wdata[3];
      cfg_d.b_strobed = wdata[2];
      cfg_d.b_in      = wdata[1];
      cfg_d.cl_in     = wdata[0];
      pc_d            = '0;
      ie_d            = '0;
    end else if (wr_cmd) begin
      pc_d[wdata[3:1]] = wdata[0];
      if (wdata[3:1] == 3'(PC_STB_A)) ie_d[IE_AIN]  = wdata[0];
      if (wdata[3:1] == 3'(PC_ACK_A)) ie_d[IE_AOUT] = wdata[0];
      if (wdata[3:1] == 3'(PC_STB_B)) ie_d[IE_B]    = wdata[0];
    end else if (wr_pc) begin
      pc_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      pc_q  <= '0;
      ie_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      pc_q  <= pc_d;
      ie_q  <= ie_d;
    end
  end

  assign cfg        = cfg_q;
  assign clr        = mode_set;
  assign pc_lat     = pc_q;
  assign inte_a_in  = ie_q[IE_AIN];
  assign inte_a_out = ie_q[IE_AOUT];
  assign inte_b     = ie_q[IE_B];

  p_modeset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (pc_q == 8'h00 && ie_q == 3'b000));

  p_bsr_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !wdata[7]) |=> ($countones(pc_q ^ $past(pc_q)) <= 1));

endmodule

// File: rtl/pp_chan.sv
module pp_chan
  import pp_pkg::*;
#(
  parameter int DW       = 8,
  parameter bit BIDIR_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  pmode_t        mode,
  input  logic          dir_in,
  input  logic          wr_port,
  input  logic          rd_port,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  input  logic          stb_n,
  input  logic          ack_n,
  output logic [DW-1:0] out_lat,
  output logic [DW-1:0] pad_oe,
  output logic [DW-1:0] rdata,
  output logic          ibf,
  output logic          obf_n,
  output logic          irq_in,
  output logic          irq_out
);

  pmode_t mode_e;
  logic   in_hs, out_hs;
  logic   stb_fall, stb_rise, ack_fall, ack_rise;

  logic          stb_q, ack_q;
  logic [DW-1:0] in_q, in_d, out_q, out_d;
  logic          ibf_q, ibf_d, obf_n_q, obf_n_d;
  logic          iin_q, iin_d, iout_q, iout_d;

  assign mode_e   = (!BIDIR_OK && mode == PM_BIDIR) ? PM_STROBED : mode;
  assign in_hs    = (mode_e == PM_BIDIR) || (mode_e == PM_STROBED && dir_in);
  assign out_hs   = (mode_e == PM_BIDIR) || (mode_e == PM_STROBED && !dir_in);
  assign stb_fall = stb_q & ~stb_n;
  assign stb_rise = ~stb_q & stb_n;
  assign ack_fall = ack_q & ~ack_n;
  assign ack_rise = ~ack_q & ack_n;

  always_comb begin
    in_d    = in_q;
    out_d   = out_q;
    ibf_d   = ibf_q;
    obf_n_d = obf_n_q;
    iin_d   = iin_q;
    iout_d  = iout_q;
    if (clr) begin
      out_d   = '0;
      ibf_d   = 1'b0;
      obf_n_d = 1'b1;
      iin_d   = 1'b0;
      iout_d  = 1'b0;
    end else begin
      if (wr_port) out_d = wdata;
      // input handshake
      if (in_hs && stb_fall) begin
        in_d  = pin_in;
        ibf_d = 1'b1;
      end else if (in_hs && rd_port) begin
        ibf_d = 1'b0;
      end
      if (in_hs && stb_rise && ibf_q && !rd_port) iin_d = 1'b1;
      else if (rd_port) iin_d = 1'b0;
      // output handshake
      if (out_hs && wr_port) obf_n_d = 1'b0;
      else if (out_hs && ack_fall) obf_n_d = 1'b1;
      if (wr_port) iout_d = 1'b0;
      else if (out_hs && ack_rise && obf_n_q) iout_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b1;
      ack_q   <= 1'b1;
      in_q    <= '0;
      out_q   <= '0;
      ibf_q   <= 1'b0;
      obf_n_q <= 1'b1;
      iin_q   <= 1'b0;
      iout_q  <= 1'b0;
    end else begin
      stb_q   <= stb_n;
      ack_q   <= ack_n;
      in_q    <= in_d;
      out_q   <= out_d;
      ibf_q   <= ibf_d;
      obf_n_q <= obf_n_d;
      iin_q   <= iin_d;
      iout_q  <= iout_d;
    end
  end

  always_comb begin
    case (mode_e)
      PM_BIDIR: pad_oe = ack_n ? '0 : '1;
      default:  pad_oe = dir_in ? '0 : '1;
    endcase
    if (dir_in || mode_e == PM_BIDIR)
      rdata = (mode_e == PM_SIMPLE) ? pin_in : in_q;
    else
      rdata = out_q;
  end

  assign out_lat = out_q;
  assign ibf     = ibf_q;
  assign obf_n   = obf_n_q;
  assign irq_in  = iin_q;
  assign irq_out = iout_q;

  p_irq_needs_ibf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iin_q) |-> $past(ibf_q));

  p_read_clears_ibf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hs && rd_port && !stb_fall && !clr) |=> !ibf_q);

  p_write_sets_obf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && wr_port && !clr) |=> !obf_n_q);

endmodule

// File: rtl/pp_cmux.sv
module pp_cmux
  import pp_pkg::*;
(
  input  cfg_t       cfg,
  input  logic [7:0] pc_lat,
  input  logic [7:0] pc_pins,
  input  logic       ibf_a,
  input  logic       obf_a_n,
  input  logic       iin_a,
  input  logic       iout_a,
  input  logic       inte_a_in,
  input  logic       inte_a_out,
  input  logic       ibf_b,
  input  logic       obf_b_n,
  input  logic       iin_b,
  input  logic       iout_b,
  input  logic       inte_b,
  output logic [7:0] pc_drv,
  output logic [7:0] pc_oe,
  output logic [7:0] pc_rd
);

  logic irq_a, irq_b, a_in_side, a_out_side;

  assign irq_a      = (inte_a_in & iin_a) | (inte_a_out & iout_a);
  assign irq_b      = inte_b & (iin_b | iout_b);
  assign a_in_side  = (cfg.a_mode == PM_BIDIR) || (cfg.a_mode == PM_STROBED && cfg.a_in);
  assign a_out_side = (cfg.a_mode == PM_BIDIR) || (cfg.a_mode == PM_STROBED && !cfg.a_in);

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      pc_drv[i] = pc_lat[i];
      pc_oe[i]  = (i < 4) ? ~cfg.cl_in : ~cfg.cu_in;
    end
    if (cfg.b_strobed) begin
      pc_oe[PC_INTR_B]  = 1'b1;
      pc_drv[PC_INTR_B] = irq_b;
      pc_oe[PC_HS_B]    = 1'b1;
      pc_drv[PC_HS_B]   = cfg.b_in ? ibf_b : obf_b_n;
      pc_oe[PC_STB_B]   = 1'b0;
    end
    if (cfg.a_mode != PM_SIMPLE) begin
      pc_oe[PC_INTR_A]  = 1'b1;
      pc_drv[PC_INTR_A] = irq_a;
    end
    if (a_in_side) begin
      pc_oe[PC_STB_A]  = 1'b0;
      pc_oe[PC_IBF_A]  = 1'b1;
      pc_drv[PC_IBF_A] = ibf_a;
    end
    if (a_out_side) begin
      pc_oe[PC_ACK_A]  = 1'b0;
      pc_oe[PC_OBF_A]  = 1'b1;
      pc_drv[PC_OBF_A] = obf_a_n;
    end
    for (int i = 0; i < 8; i++) begin
      pc_rd[i] = pc_oe[i] ? pc_drv[i] : pc_pins[i];
    end
  end

endmodule

// File: rtl/par_port_hs.sv
module par_port_hs
  import pp_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [7:0]    pc_in,
  output logic [7:0]    pc_out,
  output logic [7:0]    pc_oe
);

  localparam int RS_MSB = RST_STAGES - 1;

  logic [RS_MSB:0] rs_q;
  logic            srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RS_MSB-1:0], 1'b1};
  end
  assign srst_n = rs_q[RS_MSB];

  logic wr_a, wr_b, wr_c, wr_cmd, rd_a, rd_b;
  assign wr_a   = cs & wr & (addr == RA_PORTA);
  assign wr_b   = cs & wr & (addr == RA_PORTB);
  assign wr_c   = cs & wr & (addr == RA_PORTC);
  assign wr_cmd = cs & wr & (addr == RA_CMD);
  assign rd_a   = cs & rd & (addr == RA_PORTA);
  assign rd_b   = cs & rd & (addr == RA_PORTB);

  cfg_t       cfg;
  logic       clr;
  logic [7:0] pc_lat;
  logic       inte_a_in, inte_a_out, inte_b;

  pp_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .wr_cmd(wr_cmd), .wr_pc(wr_c),
    .wdata(wdata[7:0]), .cfg(cfg), .clr(clr), .pc_lat(pc_lat),
    .inte_a_in(inte_a_in), .inte_a_out(inte_a_out), .inte_b(inte_b)
  );

  logic [DW-1:0] rd_pa, rd_pb;
  logic          ibf_a, obf_a_n, iin_a, iout_a;
  logic          ibf_b, obf_b_n, iin_b, iout_b;
  pmode_t        mode_b;

  assign mode_b = cfg.b_strobed ? PM_STROBED : PM_SIMPLE;

  pp_chan #(.DW(DW), .BIDIR_OK(1'b1)) u_chan_a (
    .clk(clk), .rst_n(srst_n), .clr(clr), .mode(cfg.a_mode), .dir_in(cfg.a_in),
    .wr_port(wr_a), .rd_port(rd_a), .wdata(wdata), .pin_in(pa_in),
    .stb_n(pc_in[PC_STB_A]), .ack_n(pc_in[PC_ACK_A]),
    .out_lat(pa_out), .pad_oe(pa_oe), .rdata(rd_pa),
    .ibf(ibf_a), .obf_n(obf_a_n), .irq_in(iin_a), .irq_out(iout_a)
  );

  pp_chan #(.DW(DW), .BIDIR_OK(1'b0)) u_chan_b (
    .clk(clk), .rst_n(srst_n), .clr(clr), .mode(mode_b), .dir_in(cfg.b_in),
    .wr_port(wr_b), .rd_port(rd_b), .wdata(wdata), .pin_in(pb_in),
    .stb_n(pc_in[PC_STB_B]), .ack_n(pc_in[PC_STB_B]),
    .out_lat(pb_out), .pad_oe(pb_oe), .rdata(rd_pb),
    .ibf(ibf_b), .obf_n(obf_b_n), .irq_in(iin_b), .irq_out(iout_b)
  );

  logic [7:0] pc_rd;

  pp_cmux u_cmux (
    .cfg(cfg), .pc_lat(pc_lat), .pc_pins(pc_in),
    .ibf_a(ibf_a), .obf_a_n(obf_a_n), .iin_a(iin_a), .iout_a(iout_a),
    .inte_a_in(inte_a_in), .inte_a_out(inte_a_out),
    .ibf_b(ibf_b), .obf_b_n(obf_b_n), .iin_b(iin_b), .iout_b(iout_b),
    .inte_b(inte_b), .pc_drv(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd)
  );

  logic [7:0] cfg_byte;
  assign cfg_byte = {1'b1, cfg.a_mode, cfg.a_in, cfg.cu_in, cfg.b_strobed, cfg.b_in, cfg.cl_in};

  always_comb begin
    case (addr)
      RA_PORTA: rdata = rd_pa;
      RA_PORTB: rdata = rd_pb;
      RA_PORTC: rdata = DW'(pc_rd);
      default:  rdata = DW'(cfg_byte);
    endcase
  end

  p_intr_b_gated_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg.b_strobed && !inte_b) |-> !pc_out[PC_INTR_B]);

  p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == 8'h00));

endmodule

// File: tb/test_par_port_hs.sv
module test_par_port_hs;

  logic       clk = 1'b0;
  logic       rst_n, cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic [7:0] pc_in, pc_out, pc_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit mon_on  = 1'b0;

  // reference configuration model
  int t_amode = 0;
  bit t_ain   = 1'b1;
  bit t_bin   = 1'b1;

  always #2.5 clk = ~clk;

  par_port_hs i_par_port_hs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (a == 2'd3 && d[7]) begin
      t_amode = d[6] ? 2 : (d[5] ? 1 : 0);
      t_ain   = d[4];
      t_bin   = d[1];
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic set_pc(input int b, input logic v);
    @(negedge clk);
    pc_in[b] = v;
    @(negedge clk);
  endtask

  // per-clock comparison of port direction enables against the model
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      logic [7:0] ea, eb;
      if (t_amode == 2) ea = pc_in[6] ? 8'h00 : 8'hFF;
      else              ea = t_ain ? 8'h00 : 8'hFF;
      eb = t_bin ? 8'h00 : 8'hFF;
      chk("R3 pa_oe model", pa_oe, ea);
      chk("R3 pb_oe model", pb_oe, eb);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'h00;
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    bus_rd(2'd3, d); chk("R1 cmd readback", d, 8'h9B);
    bus_rd(2'd0, d); chk("R3 plain read A", d, 8'h5A);
    bus_rd(2'd1, d); chk("R2 plain read B", d, 8'hC3);

    // R3 plain outputs
    bus_wr(2'd3, 8'h80);
    chk("R3 pc_oe", pc_oe, 8'hFF);
    bus_rd(2'd3, d); chk("R2 mode byte", d, 8'h80);
    bus_wr(2'd0, 8'h11); chk("R3 pa_out", pa_out, 8'h11);
    bus_wr(2'd1, 8'h22); chk("R3 pb_out", pb_out, 8'h22);
    bus_wr(2'd2, 8'h33); chk("R2 pc_out", pc_out, 8'h33);

    // R9 bit set/reset
    bus_wr(2'd3, 8'h0F); chk("R9 set pc7", pc_out, 8'hB3);
    bus_wr(2'd3, 8'h02); chk("R9 clear pc1", pc_out, 8'hB1);

    // port A strobed input
    bus_wr(2'd3, 8'hB0);
    chk("R10 pb_out cleared", pb_out, 8'h00);
    chk("R10 pc flags cleared", pc_out & pc_oe, 8'h00);
    chk("R2 pc_oe A strobed in", pc_oe, 8'hEF);
    pa_in = 8'h77;
    set_pc(4, 1'b0); chk("R4 ibf A set", pc_out[5], 1'b1);
    pa_in = 8'h00;
    set_pc(4, 1'b1); chk("R7 intr A gated", pc_out[3], 1'b0);
    bus_wr(2'd3, 8'h09); chk("R7 intr A enabled", pc_out[3], 1'b1);
    bus_rd(2'd0, d); chk("R4 held data A", d, 8'h77);
    chk("R5 ibf A cleared", pc_out[5], 1'b0);
    chk("R5 intr A cleared", pc_out[3], 1'b0);

    // port A strobed output, port B strobed input
    bus_wr(2'd3, 8'hA6);
    chk("R2 pc_oe A out B in", pc_oe, 8'hBB);
    chk("R10 obf A high", pc_out[7], 1'b1);
    bus_wr(2'd0, 8'h3C);
    chk("R6 obf A low", pc_out[7], 1'b0);
    chk("R6 pa_out", pa_out, 8'h3C);
    bus_wr(2'd3, 8'h0D);
    set_pc(6, 1'b0); chk("R6 ack returns obf", pc_out[7], 1'b1);
    chk("R6 no intr before ack rise", pc_out[3], 1'b0);
    set_pc(6, 1'b1); chk("R6 intr on ack rise", pc_out[3], 1'b1);
    bus_wr(2'd0, 8'h3D);
    chk("R6 write clears intr", pc_out[3], 1'b0);
    chk("R6 obf A low again", pc_out[7], 1'b0);
    bus_wr(2'd3, 8'h05);
    pb_in = 8'h99;
    set_pc(2, 1'b0); chk("R4 ibf B set", pc_out[1], 1'b1);
    pb_in = 8'h12;
    set_pc(2, 1'b1); chk("R5 intr B set", pc_out[0], 1'b1);
    bus_rd(2'd1, d); chk("R4 held data B", d, 8'h99);
    chk("R5 B flags cleared", pc_out[1:0], 2'b00);
    bus_rd(2'd2, d); chk("R11 port C read", d, 8'h44);

    // port A bidirectional
    bus_wr(2'd3, 8'hC0);
    chk("R2 pc_oe bidir", pc_oe, 8'hAF);
    chk("R8 pa_oe idle", pa_oe, 8'h00);
    bus_wr(2'd0, 8'h5E);
    chk("R8 obf bidir low", pc_out[7], 1'b0);
    @(negedge clk); pc_in[6] = 1'b0;
    #1 chk("R8 pa_oe follows ack", pa_oe, 8'hFF);
    chk("R8 pa_out", pa_out, 8'h5E);
    @(negedge clk);
    chk("R8 obf bidir released", pc_out[7], 1'b1);
    set_pc(6, 1'b1); chk("R8 pa_oe released", pa_oe, 8'h00);
    pa_in = 8'hA1;
    set_pc(4, 1'b0); chk("R8 ibf bidir", pc_out[5], 1'b1);
    pa_in = 8'h00;
    set_pc(4, 1'b1);
    bus_rd(2'd0, d); chk("R8 captured A", d, 8'hA1);
    bus_wr(2'd3, 8'h03); chk("R9 bidir pc1", pc_out[2:0], 3'b010);
    bus_wr(2'd3, 8'h01); chk("R9 bidir pc0", pc_out[2:0], 3'b011);
    bus_wr(2'd3, 8'h02); chk("R9 bidir clr pc1", pc_out[2:0], 3'b001);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule